// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block replaces a hard-wired control state machine with a small stored program. A control address register selects one word of an internal control memory every cycle. The memory contents are computed in the code. Each word is either a control word or a branch word, and its top bit tells which. A control word drives a wide, almost unencoded control bus. The sequencer then steps to the next address. A branch word drives the control bus to zero. It picks the next address in one of three ways: from its own target field, from its target field when a chosen ALU flag is set, or from a mapping of the machine opcode held in the instruction register.

The block is used next to a datapath, which it does not contain. The datapath supplies the opcode and the zero and negative ALU flags. The datapath then consumes the control bus. The current control address is also exported.

Top module: `useq_sequencer`

## Requirements
- R1: While rst_n is low at a rising edge, the control address register is loaded with 0. The first word after reset is a control word, so ctl_out is 16'hA500.
- R2: When the current word is a control word, the next control address is the current address plus one, modulo 256. Address 8'hFF is followed by 8'h00.
- R3: Word layout: bit 16 is the format bit (0 = control word, 1 = branch word). For a control word, ctl_out = {addr ^ 8'hA5, addr}. The words at these addresses are branch words: 02, 12, 22, 24, 29, 31, 33, 39, 41, 50, 59, F1. Every other address holds a control word.
- R4: In a branch word, bits 9:8 select the condition and bits 7:0 hold the target. The condition codes are 00 = always, 01 = zero flag, 10 = negative flag. A branch that is taken loads the target. A branch that is not taken steps to the address plus one. The branch words are: 02 dispatch; 22 zero to 28; 31 negative to 38; 50 always to 58; 12, 24, 29, 33, 39, 41, 59 and F1 always to 00.
- R5: Condition code 11 dispatches on the opcode. The mapping is 00 to 10, 23 to 20, 2B to 30, 04 to 40, 02 to 50 and 3F to FD. Any other opcode goes to the trap address F0.
- R6: While a branch word is current, ctl_out is all zeros.
- R7: While a control word is current, neither the flags nor the opcode affect the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 6 | Machine opcode from the instruction register |
| flag_zero | input | 1 | ALU zero flag |
| flag_neg | input | 1 | ALU negative flag |
| ctl_out | output | 16 | Control bus of the current word |
| car_out | output | 8 | Current control address |

## Verification
The bench holds each of the 64 opcodes with each of the four combinations of the two flags. It starts every run from reset and follows the address trace cycle by cycle.

- Sweeping the opcodes separates the six mapped routines from the trap path.
- Sweeping the flags tells a taken zero or negative branch from one that falls through.
- At control words, the flag sweep shows the flags having no effect.
- The 3F routine runs over address FF and so checks the wrap of the increment.

// File: rtl/useq_pkg.sv
// Package: shared widths, condition codes, the computed control program
// and the opcode map. Assumes CA_W is 8, because the program uses 8-bit addresses.
package useq_pkg;
    localparam int CA_W    = 8;
    localparam int OP_W    = 6;
    localparam int CTL_W   = 16;
    localparam int COND_W  = 2;
    localparam int BR_W    = COND_W + CA_W;
    localparam int BODY_W  = (CTL_W > BR_W) ? CTL_W : BR_W;
    localparam int WORD_W  = BODY_W + 1;
    localparam int DEPTH   = 1 << CA_W;
    localparam int MAP_N   = 6;
    localparam logic [CA_W-1:0] TRAP_ADDR = 8'hF0;

    typedef enum logic [COND_W-1:0] {
        COND_ALWAYS   = 2'd0,
        COND_ZERO     = 2'd1,
        COND_NEG      = 2'd2,
        COND_DISPATCH = 2'd3
    } cond_e;

    typedef logic [WORD_W-1:0] uword_t;

    // Build a control word: format bit 0, horizontal control field.
    function automatic uword_t make_ctl(input logic [CA_W-1:0] a);
        uword_t w;
        w = '0;
        w[CTL_W-1:0] = CTL_W'({a ^ 8'hA5, a});
        return w;
    endfunction

    // Build a branch word: format bit 1, condition select and target.
    function automatic uword_t make_br(input cond_e c, input logic [CA_W-1:0] t);
        uword_t w;
        w = '0;
        w[WORD_W-1]           = 1'b1;
        w[BR_W-1:CA_W]        = c;
        w[CA_W-1:0]           = t;
        return w;
    endfunction

    // The control program, address by address.
    function automatic uword_t prog_word(input logic [CA_W-1:0] a);
        case (a)
            8'h02:   return make_br(COND_DISPATCH, 8'h00);
            8'h12:   return make_br(COND_ALWAYS,   8'h00);
            8'h22:   return make_br(COND_ZERO,     8'h28);
            8'h24:   return make_br(COND_ALWAYS,   8'h00);
            8'h29:   return make_br(COND_ALWAYS,   8'h00);
            8'h31:   return make_br(COND_NEG,      8'h38);
            8'h33:   return make_br(COND_ALWAYS,   8'h00);
            8'h39:   return make_br(COND_ALWAYS,   8'h00);
            8'h41:   return make_br(COND_ALWAYS,   8'h00);
            8'h50:   return make_br(COND_ALWAYS,   8'h58);
            8'h59:   return make_br(COND_ALWAYS,   8'h00);
            8'hF1:   return make_br(COND_ALWAYS,   8'h00);
            default: return make_ctl(a);
        endcase
    endfunction

    // Opcode of map entry i.
    function automatic logic [OP_W-1:0] map_op(input int i);
        case (i)
            0:       return 6'h00;
            1:       return 6'h23;
            2:       return 6'h2B;
            3:       return 6'h04;
            4:       return 6'h02;
            default: return 6'h3F;
        endcase
    endfunction

    // Routine start address of map entry i.
    function automatic logic [CA_W-1:0] map_tgt(input int i);
        case (i)
            0:       return 8'h10;
            1:       return 8'h20;
            2:       return 8'h30;
            3:       return 8'h40;
            4:       return 8'h50;
            default: return 8'hFD;
        endcase
    endfunction
endpackage

// File: rtl/useq_ctl_store.sv
// Control memory. A read-only array filled from the package program
// function, read without a clock. Assumes DEPTH equals 2**CA_W.
module useq_ctl_store
    import useq_pkg::*;
#(
    parameter int AW = CA_W,
    parameter int DW = WORD_W
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] word
);
    localparam int N = 1 << AW;

    logic [DW-1:0] rom [N];

    // Fill each entry from the computed program.
    for (genvar i = 0; i < N; i++) begin : g_rom
        assign rom[i] = DW'(prog_word(CA_W'(i)));
    end

    // Read the current word.
    always_comb word = rom[addr];
endmodule

// File: rtl/useq_dispatch_map.sv
// Opcode mapping. It compares the opcode with every map entry in
// parallel. A hit gives that entry's routine, and no hit gives the trap address.
// Assumes the map opcodes are distinct.
module useq_dispatch_map
    import useq_pkg::*;
#(
    parameter int OW = OP_W,
    parameter int AW = CA_W,
    parameter int N  = MAP_N
) (
    input  logic [OW-1:0] opcode,
    output logic [AW-1:0] disp_addr,
    output logic          disp_hit
);
    logic [N-1:0] hit_vec;

    // One comparator per map entry.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = (opcode == OW'(map_op(i)));
    end

    // Select the hit entry's target, else the trap address.
    always_comb begin
        disp_addr = AW'(TRAP_ADDR);
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) disp_addr = AW'(map_tgt(i));
        end
        disp_hit = |hit_vec;
    end

    // R5: at most one entry matches an opcode.
    always_comb begin
        a_r5_single_hit: assert ($onehot0(hit_vec));
    end
endmodule

// File: rtl/useq_next_addr.sv
// Next-address and output logic. It splits the current word by its format
// bit. It evaluates the branch condition, picks between increment, target
// and dispatch, and blanks the control bus for branch words.
module useq_next_addr
    import useq_pkg::*;
#(
    parameter int AW = CA_W,
    parameter int DW = WORD_W,
    parameter int CW = CTL_W
) (
    input  logic [AW-1:0] car,
    input  logic [DW-1:0] word,
    input  logic [AW-1:0] disp_addr,
    input  logic          flag_zero,
    input  logic          flag_neg,
    output logic [AW-1:0] next_car,
    output logic [CW-1:0] ctl
);
    logic          is_br;
    cond_e         cond;
    logic [AW-1:0] target;
    logic [AW-1:0] incr;
    logic          taken;

    // Field extraction.
    always_comb begin
        is_br  = word[DW-1];
        cond   = cond_e'(word[AW+COND_W-1:AW]);
        target = word[AW-1:0];
        incr   = car + AW'(1);
    end

    // Branch condition evaluation.
    always_comb begin
        case (cond)
            COND_ALWAYS: taken = 1'b1;
            COND_ZERO:   taken = flag_zero;
            COND_NEG:    taken = flag_neg;
            default:     taken = 1'b1;
        endcase
    end

    // Next address: step, or branch target, or opcode dispatch.
    always_comb begin
        if (!is_br)                     next_car = incr;
        else if (cond == COND_DISPATCH) next_car = disp_addr;
        else if (taken)                 next_car = target;
        else                            next_car = incr;
    end

    // Control bus: the word's field for control words, zero for branch words.
    always_comb ctl = is_br ? '0 : word[CW-1:0];
endmodule

// File: rtl/useq_sequencer.sv
// Top of the microcode sequencer. It holds the control address register
// and joins the store, the opcode map and the next-address logic.
// Assumes the datapath keeps opcode and flags stable around the rising edge.
module useq_sequencer
    import useq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  opcode,
    input  logic             flag_zero,
    input  logic             flag_neg,
    output logic [CTL_W-1:0] ctl_out,
    output logic [CA_W-1:0]  car_out
);
    logic [CA_W-1:0]   car_q;
    logic [CA_W-1:0]   car_d;
    logic [WORD_W-1:0] cur_word;
    logic [CA_W-1:0]   disp_addr;
    logic              disp_hit;

    useq_ctl_store #(.AW(CA_W), .DW(WORD_W)) store_i (
        .addr (car_q),
        .word (cur_word)
    );

    useq_dispatch_map #(.OW(OP_W), .AW(CA_W), .N(MAP_N)) map_i (
        .opcode    (opcode),
        .disp_addr (disp_addr),
        .disp_hit  (disp_hit)
    );

    useq_next_addr #(.AW(CA_W), .DW(WORD_W), .CW(CTL_W)) nxt_i (
        .car       (car_q),
        .word      (cur_word),
        .disp_addr (disp_addr),
        .flag_zero (flag_zero),
        .flag_neg  (flag_neg),
        .next_car  (car_d),
        .ctl       (ctl_out)
    );

    // Control address register with synchronous reset to the fetch routine.
    always_ff @(posedge clk) begin
        if (!rst_n) car_q <= '0;
        else        car_q <= car_d;
    end

    always_comb car_out = car_q;

    // R1: reset loads address 0.
    a_r1_reset_zero: assert property (@(posedge clk) !rst_n |=> car_q == '0);

    // R2: a control word steps to the next address.
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_word[WORD_W-1] |=> car_q == $past(car_q) + CA_W'(1));

    // R6: the control bus is blank for a branch word.
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cur_word[WORD_W-1] |-> ctl_out == '0);

    // R4: a zero-flag branch with the flag clear falls through.
    a_r4_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_word[WORD_W-1] && cur_word[CA_W+1:CA_W] == COND_ZERO && !flag_zero)
        |=> car_q == $past(car_q) + CA_W'(1));

    // R5: a dispatch with no map hit lands on the trap address.
    a_r5_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_word[WORD_W-1] && cur_word[CA_W+1:CA_W] == COND_DISPATCH && !disp_hit)
        |=> car_q == TRAP_ADDR);
endmodule

// File: tb/useq_sequencer_tb_top.sv
// Bench: for every opcode and flag combination it runs from reset and
// compares the address trace and the control bus with a model built from
// the requirements.
module useq_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode = 6'h00;
    logic        flag_zero = 1'b0;
    logic        flag_neg = 1'b0;
    logic [15:0] ctl_out;
    logic [7:0]  car_out;

    int total = 0;
    int bad   = 0;

    useq_sequencer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .opcode    (opcode),
        .flag_zero (flag_zero),
        .flag_neg  (flag_neg),
        .ctl_out   (ctl_out),
        .car_out   (car_out)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Branch word addresses and their condition/target (R3, R4).
    function automatic bit m_isbr(input logic [7:0] a);
        case (a)
            8'h02, 8'h12, 8'h22, 8'h24, 8'h29, 8'h31,
            8'h33, 8'h39, 8'h41, 8'h50, 8'h59, 8'hF1: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [1:0] m_cond(input logic [7:0] a);
        case (a)
            8'h02:   return 2'd3;
            8'h22:   return 2'd1;
            8'h31:   return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [7:0] m_tgt(input logic [7:0] a);
        case (a)
            8'h22:   return 8'h28;
            8'h31:   return 8'h38;
            8'h50:   return 8'h58;
            default: return 8'h00;
        endcase
    endfunction

    // Opcode map with trap (R5).
    function automatic logic [7:0] m_map(input logic [5:0] op);
        case (op)
            6'h00:   return 8'h10;
            6'h23:   return 8'h20;
            6'h2B:   return 8'h30;
            6'h04:   return 8'h40;
            6'h02:   return 8'h50;
            6'h3F:   return 8'hFD;
            default: return 8'hF0;
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        string tag;
        logic [7:0] ea;
        repeat (30000 * 20) #10;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int op = 0; op < 64; op++) begin
            for (int fl = 0; fl < 4; fl++) begin
                string       tag;
                logic [7:0]  ea;
                @(negedge clk);
                rst_n     = 1'b0;
                opcode    = 6'(op);
                flag_zero = fl[0];
                flag_neg  = fl[1];
                @(negedge clk);
                @(negedge clk);
                rst_n = 1'b1;
                ea    = 8'h00;
                tag   = "R1";
                for (int c = 0; c < 12; c++) begin
                    chk(tag, "car", 32'(car_out), 32'(ea));
                    if (m_isbr(ea)) begin
                        chk("R6", "ctl", 32'(ctl_out), 32'h0);
                        case (m_cond(ea))
                            2'd0: begin ea = m_tgt(ea); tag = "R4"; end
                            2'd1: begin ea = flag_zero ? m_tgt(ea) : ea + 8'd1; tag = "R4"; end
                            2'd2: begin ea = flag_neg ? m_tgt(ea) : ea + 8'd1; tag = "R4"; end
                            default: begin ea = m_map(opcode); tag = "R5"; end
                        endcase
                    end else begin
                        chk((c == 0) ? "R1" : "R3", "ctl", 32'(ctl_out),
                            32'({ea ^ 8'hA5, ea}));
                        ea  = ea + 8'd1;
                        tag = "R2/R7";
                    end
                    @(negedge clk);
                end
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule